// File: doc/BRIEF.md
# Management Frame Controller for an Ethernet PHY

This block lets software reach the management registers of an external Ethernet PHY through two 32-bit registers. Software first puts the word to send into the data register, then writes the control register with the PHY address, the PHY register number and one command bit (read or write). The block then clocks a standard Clause 22 management frame out on the MDC and MDIO pins. When the frame has ended, the block clears the command bit itself.

Software polls that bit to learn when the transfer is over. After a read, it picks up the 16 bits that the PHY returned from the upper half of the data register. A clock-divider threshold sits in the top byte of the control register and sets the MDC period. Hardware never changes this field, so a read-modify-write of the control register keeps it across commands.

Register map. The register select is 0 for control and 1 for data.

Control register fields:
- bits [4:0]: PHY address
- bits [9:5]: PHY register
- bit 16: read command
- bit 17: write command
- bits [31:24]: divider threshold
- all other bits read as 0

Data register fields:
- bits [15:0]: word to write
- bits [31:16]: word last read

Top module: `mdio_regif`

## Requirements
- R1: After reset both registers read 0, MDC is low and the MDIO output enable is low.
- R2: During a frame MDC has a period of 2 × (threshold + 1) system clocks. It starts low and idles low.
- R3: A write command sends 64 bits with the output enabled throughout. The bits are 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, and then the 16 data bits. Every field goes out most significant bit first, and MDIO changes only when MDC falls.
- R4: A read command sends opcode 10. The output enable drops at the start of the turnaround (bit 46 of the frame) and stays low up to the end of the frame.
- R5: During a read, MDIO input is sampled on the rising MDC edges of bits 48 to 63. The resulting 16-bit word appears in data register bits [31:16] once the command bit clears, first sampled bit as the MSB.
- R6: The command bit reads 1 for exactly 128 × (threshold + 1) clocks after the control write, and then reads 0.
- R7: Completion of a command leaves the divider threshold, PHY address and register number fields unchanged.
- R8: A control write with both command bits set starts no frame. Both bits then read 0 while MDC and the output enable stay low.
- R9: Any register write made while a command is pending is ignored. This covers both the control and the data register.
- R10: Outside a frame the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pin |

## Verification
The bench targets six corner cases:
- **Divider threshold of 0.** MDC must toggle every clock. An off-by-one divider would stretch every half period.
- **Read data sampled at the wrong edge.** The simulated PHY changes its bit only on the falling side of MDC, so sampling on the wrong edge returns a word shifted by one bit.
- **Turnaround released late.** A design that drops the output enable at bit 48 instead of bit 46 would drive against the PHY. The per-clock comparison of the enable shows this.
- **Both command bits set.** This must leave the line quiet.
- **Writes while busy.** A register write landing in the middle of a frame must not change the address fields or the outgoing data.
- **Busy length.** The busy interval is counted clock by clock, so a frame that is one bit too long or too short is caught.

// File: rtl/mdio_regif_pkg.sv
package mdio_regif_pkg;
    localparam int PHY_W   = 5;
    localparam int REG_W   = 5;
    localparam int DATA_W  = 16;
    localparam int WORD_W  = 32;

    localparam int CTRL_PHY_LSB = 0;
    localparam int CTRL_REG_LSB = 5;
    localparam int CTRL_RD_BIT  = 16;
    localparam int CTRL_WR_BIT  = 17;
    localparam int CTRL_THR_LSB = 24;
    localparam int DATA_RD_LSB  = 16;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    localparam logic [1:0] START_SEQ  = 2'b01;
    localparam logic [1:0] TA_WRITE   = 2'b10;
    localparam logic [1:0] TA_RELEASE = 2'b11;
endpackage

// File: rtl/mdio_regif_clkgen.sv
module mdio_regif_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] thr,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } clk_st_t;

    clk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        rise = 1'b0;
        fall = 1'b0;
        if (!en) begin
            st_d = '0;
        end else if (st_q.cnt == thr) begin
            st_d.cnt = '0;
            st_d.mdc = !st_q.mdc;
            rise     = !st_q.mdc;
            fall     = st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc = st_q.mdc;
endmodule

// File: rtl/mdio_regif_shifter.sv
module mdio_regif_shifter
    import mdio_regif_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_read,
    input  logic [PHY_W-1:0]  phy,
    input  logic [REG_W-1:0]  regad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              active,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    localparam int FRAME_LEN = PRE_LEN + 32;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int TA_IDX    = PRE_LEN + 14;
    localparam int DATA_IDX  = PRE_LEN + 16;
    localparam int LAST_IDX  = FRAME_LEN - 1;

    typedef struct packed {
        logic [FRAME_LEN-1:0] shreg;
        logic [CNT_W-1:0]     bitcnt;
        logic                 active;
        logic                 is_read;
        logic [DATA_W-1:0]    rdsh;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic [FRAME_LEN-1:0] frame;
    logic in_release;

    always_comb begin
        if (load_read)
            frame = {{PRE_LEN{1'b1}}, START_SEQ, OP_READ, phy, regad, TA_RELEASE, {DATA_W{1'b1}}};
        else
            frame = {{PRE_LEN{1'b1}}, START_SEQ, OP_WRITE, phy, regad, TA_WRITE, wdata};
    end

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (load) begin
            st_d.shreg   = frame;
            st_d.bitcnt  = '0;
            st_d.active  = 1'b1;
            st_d.is_read = load_read;
            st_d.rdsh    = '0;
        end else if (st_q.active) begin
            if (rise && st_q.is_read && (st_q.bitcnt >= CNT_W'(DATA_IDX)))
                st_d.rdsh = {st_q.rdsh[DATA_W-2:0], mdio_i};
            if (fall) begin
                if (st_q.bitcnt == CNT_W'(LAST_IDX)) begin
                    st_d.active = 1'b0;
                    done        = 1'b1;
                end else begin
                    st_d.shreg  = {st_q.shreg[FRAME_LEN-2:0], 1'b0};
                    st_d.bitcnt = st_q.bitcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_release = st_q.is_read && (st_q.bitcnt >= CNT_W'(TA_IDX));
    assign active     = st_q.active;
    assign mdio_o     = st_q.active && st_q.shreg[FRAME_LEN-1];
    assign mdio_oe    = st_q.active && !in_release;
    assign rd_data    = st_q.rdsh;
endmodule

// File: rtl/mdio_regif.sv
module mdio_regif
    import mdio_regif_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regad;
        logic              rd;
        logic              wr;
        logic [DIV_W-1:0]  thr;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rdat;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic              busy;
    logic              go;
    logic              cmd_rd_in;
    logic              cmd_wr_in;
    logic              sh_active;
    logic              sh_done;
    logic [DATA_W-1:0] sh_rdata;
    logic              mdc_rise;
    logic              mdc_fall;
    logic [DIV_W-1:0]  thr_cur;
    logic [DATA_W-1:0] rdat_cur;
    logic [PHY_W-1:0]  phy_cur;
    logic              rd_cmd;
    logic              wr_cmd;

    assign busy      = st_q.rd | st_q.wr;
    assign cmd_rd_in = reg_wdata[CTRL_RD_BIT];
    assign cmd_wr_in = reg_wdata[CTRL_WR_BIT];
    assign go        = reg_wr && !busy && (reg_sel == SEL_CTRL) && (cmd_rd_in ^ cmd_wr_in);

    always_comb begin
        st_d = st_q;
        if (sh_done) begin
            st_d.rd = 1'b0;
            st_d.wr = 1'b0;
            if (st_q.rd) st_d.rdat = sh_rdata;
        end else if (reg_wr && !busy) begin
            if (reg_sel == SEL_CTRL) begin
                st_d.phy   = reg_wdata[CTRL_PHY_LSB +: PHY_W];
                st_d.regad = reg_wdata[CTRL_REG_LSB +: REG_W];
                st_d.thr   = reg_wdata[CTRL_THR_LSB +: DIV_W];
                st_d.rd    = cmd_rd_in && !cmd_wr_in;
                st_d.wr    = cmd_wr_in && !cmd_rd_in;
            end else begin
                st_d.wdat = reg_wdata[DATA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_CTRL) begin
            reg_rdata[CTRL_PHY_LSB +: PHY_W] = st_q.phy;
            reg_rdata[CTRL_REG_LSB +: REG_W] = st_q.regad;
            reg_rdata[CTRL_RD_BIT]           = st_q.rd;
            reg_rdata[CTRL_WR_BIT]           = st_q.wr;
            reg_rdata[CTRL_THR_LSB +: DIV_W] = st_q.thr;
        end else begin
            reg_rdata[DATA_W-1:0]            = st_q.wdat;
            reg_rdata[DATA_RD_LSB +: DATA_W] = st_q.rdat;
        end
    end

    mdio_regif_clkgen #(
        .DIV_W (DIV_W)
    ) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sh_active),
        .thr   (st_q.thr),
        .mdc   (mdc),
        .rise  (mdc_rise),
        .fall  (mdc_fall)
    );

    mdio_regif_shifter #(
        .PRE_LEN (PRE_LEN)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go),
        .load_read (cmd_rd_in),
        .phy       (reg_wdata[CTRL_PHY_LSB +: PHY_W]),
        .regad     (reg_wdata[CTRL_REG_LSB +: REG_W]),
        .wdata     (st_q.wdat),
        .rise      (mdc_rise),
        .fall      (mdc_fall),
        .mdio_i    (mdio_i),
        .active    (sh_active),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (sh_done),
        .rd_data   (sh_rdata)
    );

    assign thr_cur  = st_q.thr;
    assign rdat_cur = st_q.rdat;
    assign phy_cur  = st_q.phy;
    assign rd_cmd   = st_q.rd;
    assign wr_cmd   = st_q.wr;
endmodule

// File: rtl/mdio_regif_chk.sv
module mdio_regif_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             rd_cmd,
    input logic             wr_cmd,
    input logic [DIV_W-1:0] thr,
    input logic [15:0]      rdat,
    input logic [4:0]       phy
);
    logic busy;
    assign busy = rd_cmd | wr_cmd;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));                                   // R10

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_cmd && wr_cmd));                                            // R8

    AST_THR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(thr));                                          // R7

    AST_PHY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(phy));                                          // R9

    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R3

    AST_END_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(mdc));                                     // R6

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rdat));                        // R5
endmodule

bind mdio_regif mdio_regif_chk #(
    .DIV_W (DIV_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rd_cmd  (rd_cmd),
    .wr_cmd  (wr_cmd),
    .thr     (thr_cur),
    .rdat    (rdat_cur),
    .phy     (phy_cur)
);

// File: tb/mdio_regif_tb.sv
module mdio_regif_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = !clk;

    mdio_regif u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    // behavioural reference
    bit        m_busy, m_rd;
    int        m_t, m_thr;
    logic [63:0] m_frame;
    logic [15:0] m_wdat;
    logic [15:0] phy_val = 16'h0000;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_rd = 0; m_t = 0; m_thr = 0; m_wdat = '0; m_frame = '0;
        end else if (m_busy) begin
            if (m_t == 128 * (m_thr + 1) - 1) begin
                m_busy = 0;
                m_t    = 0;
            end else begin
                m_t++;
            end
        end else if (reg_wr) begin
            if (reg_sel == 1'b1) begin
                m_wdat = reg_wdata[15:0];
            end else if (reg_wdata[16] ^ reg_wdata[17]) begin
                m_busy  = 1;
                m_t     = 0;
                m_rd    = reg_wdata[16];
                m_thr   = int'(reg_wdata[31:24]);
                m_frame = {32'hFFFF_FFFF, 2'b01, (m_rd ? 2'b10 : 2'b01),
                           reg_wdata[4:0], reg_wdata[9:5], 2'b10, m_wdat};
            end
        end
    end

    // per-clock comparison and PHY model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (m_busy) begin
                int half;
                int bidx;
                bit exp_mdc, exp_oe;
                half    = m_thr + 1;
                bidx    = m_t / (2 * half);
                exp_mdc = ((m_t / half) % 2) == 1;
                exp_oe  = !(m_rd && bidx >= 46);
                chk(mdc == exp_mdc, "R2", "mdc", longint'(mdc), longint'(exp_mdc));
                chk(mdio_oe == exp_oe, m_rd ? "R4" : "R3", "mdio_oe",
                    longint'(mdio_oe), longint'(exp_oe));
                if (exp_oe)
                    chk(mdio_o == m_frame[63 - bidx], "R3", "mdio_o",
                        longint'(mdio_o), longint'(m_frame[63 - bidx]));
                mdio_i = (m_rd && bidx >= 48) ? phy_val[15 - (bidx - 48)] : 1'b1;
            end else begin
                chk(!mdc && !mdio_oe, "R10", "idle mdc/oe",
                    longint'({mdc, mdio_oe}), 0);
                mdio_i = 1'b1;
            end
        end
    end

    task automatic reg_write(input logic sel, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic sel, output logic [31:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic wait_idle(output int cycles);
        logic [31:0] v;
        cycles = 0;
        reg_read(1'b0, v);
        while (v[17:16] != 2'b00) begin
            cycles++;
            @(negedge clk);
            reg_read(1'b0, v);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input int thr, input int phy,
                                              input int rg, input bit rd, input bit wr);
        logic [31:0] w;
        w = '0;
        w[31:24] = 8'(thr);
        w[4:0]   = 5'(phy);
        w[9:5]   = 5'(rg);
        w[16]    = rd;
        w[17]    = wr;
        return w;
    endfunction

    initial begin
        #(200000 * CLK_PERIOD);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cyc;

        repeat (3) @(negedge clk);
        // R1: reset state
        reg_read(1'b0, v); chk(v == 0, "R1", "ctrl after reset", v, 0);
        reg_read(1'b1, v); chk(v == 0, "R1", "data after reset", v, 0);
        chk(!mdc && !mdio_oe, "R1", "pins after reset", {mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // write frame, threshold 1
        reg_write(1'b1, 32'h0000_A5C3);
        reg_write(1'b0, ctrl_word(1, 5, 17, 0, 1));
        wait_idle(cyc);
        chk(cyc == 256, "R6", "write busy cycles", cyc, 256);
        reg_read(1'b0, v);
        chk(v == ctrl_word(1, 5, 17, 0, 0), "R7", "ctrl after write", v,
            ctrl_word(1, 5, 17, 0, 0));

        // read frame, threshold 0
        phy_val = 16'h3C5A;
        reg_write(1'b0, ctrl_word(0, 31, 2, 1, 0));
        wait_idle(cyc);
        chk(cyc == 128, "R6", "read busy cycles thr0", cyc, 128);
        reg_read(1'b1, v);
        chk(v[31:16] == 16'h3C5A, "R5", "read data thr0", v[31:16], 16'h3C5A);
        chk(v[15:0] == 16'hA5C3, "R5", "write word kept", v[15:0], 16'hA5C3);

        // read frame, threshold 3
        phy_val = 16'h8001;
        reg_write(1'b0, ctrl_word(3, 9, 0, 1, 0));
        wait_idle(cyc);
        chk(cyc == 512, "R6", "read busy cycles thr3", cyc, 512);
        reg_read(1'b1, v);
        chk(v[31:16] == 16'h8001, "R5", "read data thr3", v[31:16], 16'h8001);
        reg_read(1'b0, v);
        chk(v == ctrl_word(3, 9, 0, 0, 0), "R7", "ctrl after read", v,
            ctrl_word(3, 9, 0, 0, 0));

        // both command bits
        reg_write(1'b0, ctrl_word(2, 4, 4, 1, 1));
        reg_read(1'b0, v);
        chk(v[17:16] == 2'b00, "R8", "both cmd bits", v[17:16], 0);
        repeat (20) begin
            @(negedge clk); #1;
            chk(!mdc && !mdio_oe, "R8", "line quiet", {mdc, mdio_oe}, 0);
        end

        // writes while busy
        reg_write(1'b1, 32'h0000_0F0F);
        reg_write(1'b0, ctrl_word(0, 12, 7, 0, 1));
        repeat (10) @(negedge clk);
        reg_write(1'b0, ctrl_word(5, 3, 3, 0, 1));
        reg_write(1'b1, 32'h0000_1111);
        wait_idle(cyc);
        reg_read(1'b0, v);
        chk(v == ctrl_word(0, 12, 7, 0, 0), "R9", "ctrl after busy write", v,
            ctrl_word(0, 12, 7, 0, 0));
        reg_read(1'b1, v);
        chk(v[15:0] == 16'h0F0F, "R9", "data after busy write", v[15:0], 16'h0F0F);

        // one more write frame with the kept word, threshold 2
        reg_write(1'b0, ctrl_word(2, 1, 30, 0, 1));
        wait_idle(cyc);
        chk(cyc == 384, "R6", "write busy cycles thr2", cyc, 384);
        repeat (5) @(negedge clk);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule